// File: doc/BRIEF.md
# Codec Serial Port (TDM / I2S master)

This block is the master side of a serial audio link. It makes a serial clock at half the system clock rate and a frame sync, and it moves data words out on a data-out line and in from a data-in line, one word per time slot. Two framings are offered: a multichannel time-division mode, where a one-bit-wide sync pulse precedes slot 0, and an I2S mode, where a square word-select signal with a 50% duty cycle carries two words per period.

Software sets it up through a small register port: word length, slots per frame, separate transmit and receive slot masks, what the data line does in slots nobody transmits in, and how many words pass between interrupts. Transmit words come from a four-entry buffer and received words go to a four-entry buffer. A shared pointer walks both buffers, one step per slot that is enabled for either direction. Setup is locked while the port runs. Enabling the port always begins a fresh frame.

Top module: `codec_serial_port`

Register map (write `cfg_wr`, address `cfg_addr`, read data `cfg_rdata` is combinational):
- 0 control: bit 0 run, bits 2:1 framing (00 TDM, 01 I2S, 10/11 act as TDM), bit 3 release line in idle slots, bits 7:4 word bits minus one, bits 11:8 slots per frame minus one, bits 13:12 buffer depth minus one.
- 1 transmit slot mask, 2 receive slot mask (bit n is slot n).
- 3 status: bit 0 interrupt flag, cleared by writing 1 to bit 0.
- 4..7 transmit buffer entries 0..3. 8..11 receive buffer entries 0..3, read only.

## Requirements
- R1: While running, `sclk` toggles on every system clock, starting low in the first cycle after the run bit is written; it is low while stopped.
- R2: In TDM mode a frame lasts (word bits) x (slots) serial clocks, and `fsync` is high for exactly the serial clock that holds the last bit of the last slot, changing with the falling edge of `sclk`. With control bits 11:8 = 1111 and 16-bit words the frame is 256 serial clocks.
- R3: In I2S mode the slot count field is ignored and the frame is two words; `fsync` is low for slot 0 and high for slot 1, and each of its edges falls one serial clock before the first bit of the word it announces.
- R4: Transmit words leave MSB first, each bit changing on a falling edge of `sclk` and held through the following rising edge.
- R5: A slot transmits only if its bit in the transmit mask is set; bit 0 is the first slot after the sync.
- R6: In a slot that does not transmit, and while stopped, `sdo` is 0; `sdo_oe` is 1 when control bit 3 is 0 and 0 when it is 1.
- R7: `sdi` is sampled on each rising edge of `sclk` in slots enabled in the receive mask; the word, right-aligned, reaches the receive buffer in the system clock after the rising edge that samples its last bit.
- R8: The pointer starts at 0 and steps after each slot enabled in either mask, wrapping after entry (depth field); transmit slots read and receive slots write the entry it names.
- R9: The interrupt flag sets when the pointer wraps, stays set until cleared through status bit 0, and a set in the same cycle as a clear wins.
- R10: While running, writes to the masks and to control fields other than the run bit are ignored.
- R11: Writing the run bit starts with one lead-in serial clock (sync asserted in TDM, word-select low in I2S, no data) followed by slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| irq | output | 1 | Sticky interrupt flag |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync (TDM) or word select (I2S) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| sdi | input | 1 | Serial data in |

## Verification
Counting from the system clock edge that captures the run bit, `sclk` is low in cycle 0 and the serial clock of cycle t is t/2; `fsync`, `sdo` and `sdo_oe` belong to serial clock c during system cycles 2c and 2c+1, and data in serial clock c is taken at the edge ending cycle 2c. The receive buffer and the flag therefore change one system cycle later, in cycle 2c+1, and a status clear takes effect in the cycle after its write. The bench samples every output on the falling system clock edge of every cycle of each run and compares it to values derived from those cycle formulas, then reads the buffers back after stopping.

// File: rtl/csp_pkg.sv
`timescale 1ns/1ps
package csp_pkg;
  localparam int DW    = 16;
  localparam int NSLOT = 16;
  localparam int BUF_N = 4;
  localparam int AW    = 4;
  localparam int WB    = $clog2(DW);
  localparam int SB    = $clog2(NSLOT);
  localparam int PB    = $clog2(BUF_N);

  typedef enum logic [1:0] {
    FM_TDM  = 2'b00,
    FM_I2S  = 2'b01,
    FM_RSV2 = 2'b10,
    FM_RSV3 = 2'b11
  } fmode_e;

  typedef struct packed {
    logic [PB-1:0] blen;
    logic [SB-1:0] nslot_m1;
    logic [WB-1:0] wbits_m1;
    logic          hiz;
    fmode_e        mode;
    logic          en;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_TXM  = 4'd1;
  localparam logic [AW-1:0] A_RXM  = 4'd2;
  localparam logic [AW-1:0] A_STAT = 4'd3;
  localparam logic [AW-1:0] A_TXB  = 4'd4;
  localparam logic [AW-1:0] A_RXB  = 4'd8;
endpackage

// File: rtl/csp_regs.sv
`timescale 1ns/1ps
module csp_regs
  import csp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     irq,
  input  logic [BUF_N-1:0][DW-1:0] rxbuf,
  output ctrl_t                    ctrl,
  output logic [NSLOT-1:0]         txmask,
  output logic [NSLOT-1:0]         rxmask,
  output logic [BUF_N-1:0][DW-1:0] txbuf,
  output logic                     clr_irq,
  output logic [DW-1:0]            rdata
);
  ctrl_t            ctrl_d;
  logic [NSLOT-1:0] txm_d;
  logic [NSLOT-1:0] rxm_d;
  logic             hit_ctrl;
  logic             hit_txm;
  logic             hit_rxm;

  always_comb begin
    hit_ctrl = wr && (addr == A_CTRL);
    hit_txm  = wr && (addr == A_TXM);
    hit_rxm  = wr && (addr == A_RXM);
    clr_irq  = wr && (addr == A_STAT) && wdata[0];
    ctrl_d   = ctrl;
    if (hit_ctrl) begin
      if (ctrl.en) ctrl_d.en = wdata[0];
      else         ctrl_d    = ctrl_t'(wdata[CTRL_BITS-1:0]);
    end
    txm_d = (hit_txm && !ctrl.en) ? wdata[NSLOT-1:0] : txmask;
    rxm_d = (hit_rxm && !ctrl.en) ? wdata[NSLOT-1:0] : rxmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      txmask <= '0;
      rxmask <= '0;
    end else begin
      ctrl   <= ctrl_d;
      txmask <= txm_d;
      rxmask <= rxm_d;
    end
  end

  for (genvar gi = 0; gi < BUF_N; gi++) begin : g_txb
    logic ld;
    always_comb ld = wr && (addr == (A_TXB + AW'(gi)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  txbuf[gi] <= '0;
      else if (ld) txbuf[gi] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[CTRL_BITS-1:0] = ctrl;
    if (addr == A_TXM)  rdata[NSLOT-1:0] = txmask;
    if (addr == A_RXM)  rdata[NSLOT-1:0] = rxmask;
    if (addr == A_STAT) rdata[0] = irq;
    for (int i = 0; i < BUF_N; i++) begin
      if (addr == (A_TXB + AW'(i))) rdata = txbuf[i];
      if (addr == (A_RXB + AW'(i))) rdata = rxbuf[i];
    end
  end
endmodule

// File: rtl/csp_timing.sv
`timescale 1ns/1ps
module csp_timing
  import csp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  output logic          sclk,
  output logic          rise_ev,
  output logic          slot_start,
  output logic          lead,
  output logic [SB-1:0] slot,
  output logic [WB-1:0] bitc,
  output logic          last_bit,
  output logic          fsync
);
  logic          ph, ph_d;
  logic          lead_d;
  logic [SB-1:0] slot_d;
  logic [WB-1:0] bitc_d;
  logic          i2s;
  logic [SB-1:0] nm1;
  logic          fall_ev;

  always_comb begin
    i2s        = (ctrl.mode == FM_I2S);
    nm1        = i2s ? SB'(1) : ctrl.nslot_m1;
    last_bit   = (bitc == ctrl.wbits_m1);
    sclk       = ph && ctrl.en;
    rise_ev    = ctrl.en && !ph;
    fall_ev    = ctrl.en && ph;
    slot_start = fall_ev && (lead || last_bit);
  end

  // next state of the bit/slot walk
  always_comb begin
    ph_d   = ph;
    lead_d = lead;
    slot_d = slot;
    bitc_d = bitc;
    if (!ctrl.en) begin
      ph_d   = 1'b0;
      lead_d = 1'b1;
      slot_d = '0;
      bitc_d = '0;
    end else begin
      ph_d = !ph;
      if (fall_ev) begin
        if (lead) begin
          lead_d = 1'b0;
          slot_d = '0;
          bitc_d = '0;
        end else if (last_bit) begin
          bitc_d = '0;
          slot_d = (slot == nm1) ? '0 : slot + SB'(1);
        end else begin
          bitc_d = bitc + WB'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      lead <= 1'b1;
      slot <= '0;
      bitc <= '0;
    end else begin
      ph   <= ph_d;
      lead <= lead_d;
      slot <= slot_d;
      bitc <= bitc_d;
    end
  end

  // sync / word select
  always_comb begin
    if (!ctrl.en)     fsync = 1'b0;
    else if (i2s)     fsync = lead ? 1'b0 : (last_bit ? ~slot[0] : slot[0]);
    else              fsync = lead || ((slot == nm1) && last_bit);
  end
endmodule

// File: rtl/csp_datapath.sv
`timescale 1ns/1ps
module csp_datapath
  import csp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_t                    ctrl,
  input  logic [NSLOT-1:0]         txmask,
  input  logic [NSLOT-1:0]         rxmask,
  input  logic [BUF_N-1:0][DW-1:0] txbuf,
  input  logic                     sdi,
  input  logic                     rise_ev,
  input  logic                     slot_start,
  input  logic                     lead,
  input  logic [SB-1:0]            slot,
  input  logic [WB-1:0]            bitc,
  input  logic                     last_bit,
  input  logic                     clr_irq,
  output logic [BUF_N-1:0][DW-1:0] rxbuf,
  output logic                     irq,
  output logic                     sdo,
  output logic                     sdo_oe
);
  logic [PB-1:0] ptr, ptr_d;
  logic [DW-1:0] txw, txw_d;
  logic [DW-1:0] rxsr, rxsr_d;
  logic          irq_d;
  logic          tx_on, rx_on, word_end, wrap;
  logic [DW-1:0] wmask;

  always_comb begin
    tx_on    = ctrl.en && !lead && txmask[slot];
    rx_on    = ctrl.en && !lead && rxmask[slot];
    word_end = rise_ev && last_bit && (tx_on || rx_on);
    wrap     = (ptr == ctrl.blen);
    wmask    = {DW{1'b1}} >> (WB'(DW-1) - ctrl.wbits_m1);

    rxsr_d = (rise_ev && rx_on) ? {rxsr[DW-2:0], sdi} : rxsr;
    txw_d  = slot_start ? txbuf[ptr] : txw;

    if (!ctrl.en)      ptr_d = '0;
    else if (word_end) ptr_d = wrap ? '0 : ptr + PB'(1);
    else               ptr_d = ptr;

    if (word_end && wrap) irq_d = 1'b1;
    else if (clr_irq)     irq_d = 1'b0;
    else                  irq_d = irq;

    sdo    = tx_on ? txw[ctrl.wbits_m1 - bitc] : 1'b0;
    sdo_oe = tx_on || !ctrl.hiz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      txw  <= '0;
      rxsr <= '0;
      irq  <= 1'b0;
    end else begin
      ptr  <= ptr_d;
      txw  <= txw_d;
      rxsr <= rxsr_d;
      irq  <= irq_d;
    end
  end

  for (genvar gi = 0; gi < BUF_N; gi++) begin : g_rxb
    logic st;
    always_comb st = word_end && rx_on && (ptr == PB'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rxbuf[gi] <= '0;
      else if (st) rxbuf[gi] <= rxsr_d & wmask;
    end
  end
endmodule

// File: rtl/codec_serial_port.sv
`timescale 1ns/1ps
module codec_serial_port
  import csp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq,
  output logic          sclk,
  output logic          fsync,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          sdi
);
  ctrl_t                    ctrl_q;
  logic [NSLOT-1:0]         txmask, rxmask;
  logic [BUF_N-1:0][DW-1:0] txbuf, rxbuf;
  logic                     clr_irq;
  logic                     rise_ev, slot_start, lead, last_bit;
  logic [SB-1:0]            slot;
  logic [WB-1:0]            bitc;

  csp_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .irq    (irq),
    .rxbuf  (rxbuf),
    .ctrl   (ctrl_q),
    .txmask (txmask),
    .rxmask (rxmask),
    .txbuf  (txbuf),
    .clr_irq(clr_irq),
    .rdata  (cfg_rdata)
  );

  csp_timing u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_q),
    .sclk      (sclk),
    .rise_ev   (rise_ev),
    .slot_start(slot_start),
    .lead      (lead),
    .slot      (slot),
    .bitc      (bitc),
    .last_bit  (last_bit),
    .fsync     (fsync)
  );

  csp_datapath u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_q),
    .txmask    (txmask),
    .rxmask    (rxmask),
    .txbuf     (txbuf),
    .sdi       (sdi),
    .rise_ev   (rise_ev),
    .slot_start(slot_start),
    .lead      (lead),
    .slot      (slot),
    .bitc      (bitc),
    .last_bit  (last_bit),
    .clr_irq   (clr_irq),
    .rxbuf     (rxbuf),
    .irq       (irq),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );
endmodule

// File: rtl/csp_checker.sv
`timescale 1ns/1ps
module csp_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic i2s,
  input logic sclk,
  input logic fsync,
  input logic sdo,
  input logic sdo_oe,
  input logic irq,
  input logic clr
);
  assert_sclk_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (sclk != $past(sclk)));

  assert_sync_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !i2s && $rose(fsync)) |-> !sclk);

  assert_ws_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && i2s && (fsync != $past(fsync))) |-> $fell(sclk));

  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && sclk) |-> ($stable(sdo) && $stable(sdo_oe)));

  assert_released_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
endmodule

bind codec_serial_port csp_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (ctrl_q.en),
  .i2s   (ctrl_q.mode == csp_pkg::FM_I2S),
  .sclk  (sclk),
  .fsync (fsync),
  .sdo   (sdo),
  .sdo_oe(sdo_oe),
  .irq   (irq),
  .clr   (cfg_wr && (cfg_addr == csp_pkg::A_STAT) && cfg_wdata[0])
);

// File: tb/codec_serial_port_test.sv
`timescale 1ns/1ps
module codec_serial_port_test;
  import csp_pkg::*;

  logic          clk, rst_n, cfg_wr;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata, cfg_rdata;
  logic          irq, sclk, fsync, sdo, sdo_oe, sdi;

  int nvec, nbad;
  int W, N, L, B;
  logic [15:0] txm, rxm;
  logic [15:0] tb [4];
  logic [15:0] exp_rx [4];

  codec_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq), .sclk(sclk),
    .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    cfg_addr = a;
    #1;
    chk(req, 32'(cfg_rdata), 32'(exp));
  endtask

  function automatic logic sv(input int c, input int seed);
    int h;
    h = c * 29 + seed * 3 + (c >> 2);
    return h[1] ^ h[3];
  endfunction

  task automatic run(input int md, input int wm1, input int nm1, input int hz,
                     input int bl, input logic [15:0] tm, input logic [15:0] rm,
                     input int frames, input int seed, input bit ign);
    int T, c, cp, p, s, b, k, txidx;
    logic [31:0] rxacc;
    bit setnow, pend, txon, iexp;
    logic [15:0] ctrlw, mask;
    logic efs, esdo, eoe;
    W = wm1 + 1; N = (md == 1) ? 2 : nm1 + 1; L = W * N; B = bl + 1;
    txm = tm; rxm = rm;
    mask = 16'((32'd1 << W) - 1);
    ctrlw = {2'b00, 2'(bl), 4'(nm1), 4'(wm1), 1'(hz), 2'(md), 1'b1};
    for (int i = 0; i < 4; i++) begin
      tb[i] = 16'(seed * 4099 + i * 1237 + 23100);
      wr(A_TXB + 4'(i), tb[i]);
    end
    wr(A_TXM, txm);
    wr(A_RXM, rxm);
    wr(A_STAT, 16'h0001);
    iexp = 1'b0; k = 0; rxacc = '0; pend = 1'b0; txidx = 0;
    wr(A_CTRL, ctrlw);
    T = 2 * (1 + frames * L);
    for (int t = 0; t < T; t++) begin
      c = t / 2;
      setnow = 1'b0;
      if (t > 0 && ((t - 1) % 2 == 0)) begin
        cp = (t - 1) / 2;
        if (cp >= 1) begin
          p = (cp - 1) % L; s = p / W; b = p % W;
          if (rxm[s]) rxacc = (rxacc << 1) | 32'(sv(cp, seed));
          if (b == W - 1 && (txm[s] || rxm[s])) begin
            if (rxm[s]) exp_rx[k % B] = rxacc[15:0] & mask;
            if (k % B == B - 1) setnow = 1'b1;
            k++;
          end
        end
      end
      if (setnow) iexp = 1'b1;
      else if (pend) iexp = 1'b0;
      pend = 1'b0;
      cfg_wr = 1'b0;
      txon = 1'b0; b = 0; s = 0;
      if (c >= 1) begin
        p = (c - 1) % L; s = p / W; b = p % W;
        if (t % 2 == 0 && b == 0) txidx = k % B;
        txon = txm[s];
      end
      esdo = txon ? tb[txidx][W - 1 - b] : 1'b0;
      eoe  = txon || (hz == 0);
      efs  = (md == 1) ? ((c % L) >= W) : ((c % L) == 0);
      chk("R1 sclk phase", 32'(sclk), 32'(t % 2));
      if (c == 0)       chk("R11 lead-in sync", 32'(fsync), 32'(efs));
      else if (md == 1) chk("R3 word select", 32'(fsync), 32'(efs));
      else              chk("R2 frame sync", 32'(fsync), 32'(efs));
      if (txon) chk("R4 R5 tx bit", 32'(sdo), 32'(esdo));
      else      chk("R6 idle data", 32'(sdo), 32'(esdo));
      chk("R6 drive enable", 32'(sdo_oe), 32'(eoe));
      chk("R8 R9 interrupt flag", 32'(irq), 32'(iexp));
      if (t % 2 == 0) sdi = sv(c, seed);
      if (ign && t == 9) begin
        cfg_wr = 1'b1; cfg_addr = A_CTRL; cfg_wdata = ctrlw ^ 16'h3FF6;
      end else if (ign && t == 13) begin
        cfg_wr = 1'b1; cfg_addr = A_TXM; cfg_wdata = ~txm;
      end else if (ign && t == 17) begin
        cfg_wr = 1'b1; cfg_addr = A_RXM; cfg_wdata = 16'h0000;
      end else if (iexp && t % 5 == 2 && t > 20) begin
        cfg_wr = 1'b1; cfg_addr = A_STAT; cfg_wdata = 16'h0001; pend = 1'b1;
      end
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    wr(A_CTRL, ctrlw & 16'hFFFE);
    chk("R1 stopped sclk", 32'(sclk), 32'd0);
    chk("R6 stopped data", 32'(sdo), 32'd0);
    chk("R6 stopped enable", 32'(sdo_oe), 32'(hz == 0));
    chk("R2 stopped sync", 32'(fsync), 32'd0);
    if (ign) begin
      rd_chk(A_CTRL, ctrlw & 16'hFFFE, "R10 control kept");
      rd_chk(A_TXM, txm, "R10 tx mask kept");
      rd_chk(A_RXM, rxm, "R10 rx mask kept");
    end
    for (int i = 0; i < 4; i++) rd_chk(A_RXB + 4'(i), exp_rx[i], "R7 R8 rx buffer");
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog R1: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    nvec = 0; nbad = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; sdi = 1'b0;
    for (int i = 0; i < 4; i++) exp_rx[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sclk", 32'(sclk), 32'd0);
    chk("R2 reset sync", 32'(fsync), 32'd0);
    chk("R9 reset flag", 32'(irq), 32'd0);
    chk("R6 reset data", 32'(sdo), 32'd0);
    chk("R6 reset enable", 32'(sdo_oe), 32'd1);
    rd_chk(A_CTRL, 16'h0000, "R10 reset control");
    for (int i = 0; i < 6; i++)
      run(0, 3, 3, i % 2, i % 4, 16'((i * 7 + 1) & 15), 16'((i * 11 + 6) & 15), 4, i + 1, 1'b0);
    run(0, 15, 15, 0, 0, 16'h0001, 16'h0001, 3, 11, 1'b0);
    run(0, 7, 2, 1, 3, 16'h0005, 16'h0006, 6, 12, 1'b1);
    run(1, 4, 7, 0, 1, 16'h0003, 16'h0003, 6, 13, 1'b1);
    run(1, 15, 0, 1, 2, 16'h0001, 16'h0002, 5, 14, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule